// File: doc/BRIEF.md
# Binary-Assisted Gray Up-Counter

This block is a free-running up-counter that holds two registers of equal width side by side: a plain binary count and its reflected Gray code. Each register has its own next-value path. The Gray register's next value comes from the binary register's next value, not from its current output. Both registers therefore load on the same clock edge, and the Gray output never trails the binary output by a cycle.

Typical uses are the pointer of a dual-clock FIFO and the address source for a storage array. The binary output addresses the memory. The Gray output goes to comparators or synchronizers in another clock domain. Because only one Gray bit changes per count, an asynchronous observer sees either the old code or the new one and never a mix of the two. The cost is two flip-flops per counter bit.

Top module: `gray_bin_counter`

## Requirements
- R1: A synchronous active-high reset clears both the binary output and the Gray output to zero on the next rising clock edge.
- R2: On a rising edge with enable high and reset low, the binary output becomes its previous value plus one, modulo 2^WIDTH.
- R3: On a rising edge with enable low and reset low, both outputs keep their values.
- R4: For every bit i below WIDTH-1, Gray bit i equals binary bit i XOR binary bit i+1 of the same cycle. The Gray MSB equals the binary MSB. This holds after every edge, so the Gray output is never one count behind.
- R5: Across each enabled count, including the wrap from all ones to zero, the Gray output changes in exactly one bit position.
- R6: The binary output wraps from all ones to zero, and the Gray output wraps at the same time from a 1 in the MSB only to zero.
- R7: WIDTH is a parameter with a minimum of 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by both registers |
| rst | input | 1 | Synchronous active-high clear |
| en | input | 1 | Count enable shared by both registers |
| bin_o | output | WIDTH | Binary count |
| gray_o | output | WIDTH | Gray-coded count, same cycle as bin_o |

## Verification
If the Gray next-value path took the current binary value instead of the next one, gray_o would encode the previous count. The per-cycle XOR relation between the two outputs would then fail on the first enabled edge after reset.

A wrong carry or a broken hold shows at the binary port on the edge where it happens. The bench compares every cycle against a queue of expected pairs. The wrap case appears only after 2^WIDTH counts, so the bench runs the count past all ones at least once.

// File: rtl/gray_bin_counter_pkg.sv
package gray_bin_counter_pkg;

    // Reflected Gray code of a binary value, for any width.
    function automatic logic [63:0] to_gray(input logic [63:0] b);
        return b ^ (b >> 1);
    endfunction

endpackage

// File: rtl/gray_enc_stage.sv
module gray_enc_stage #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] bin_d,
    output logic [WIDTH-1:0] gray_d
);
    // Each Gray bit below the MSB is the XOR of two adjacent binary bits.
    for (genvar i = 0; i < WIDTH - 1; i++) begin : g_xor
        assign gray_d[i] = bin_d[i] ^ bin_d[i+1];
    end
    // The Gray MSB copies the binary MSB.
    assign gray_d[WIDTH-1] = bin_d[WIDTH-1];
endmodule

// File: rtl/bin_next_stage.sv
module bin_next_stage #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] bin_q,
    input  logic             rst,
    input  logic             en,
    output logic [WIDTH-1:0] bin_d
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_comb begin
        if (rst)
            bin_d = '0;
        else if (en)
            bin_d = bin_q + ONE;   // wraps naturally modulo 2^WIDTH
        else
            bin_d = bin_q;
    end
endmodule

// File: rtl/gray_bin_counter.sv
module gray_bin_counter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic [WIDTH-1:0] bin_o,
    output logic [WIDTH-1:0] gray_o
);
    // R7: the width must be at least two bits.
    initial begin
        if (WIDTH < 2) $error("gray_bin_counter: WIDTH must be >= 2");
    end

    typedef struct packed {
        logic [WIDTH-1:0] bin;
        logic [WIDTH-1:0] gray;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic [WIDTH-1:0] bin_nx_d, gray_nx_d;

    bin_next_stage #(.WIDTH(WIDTH)) u_bin_next (
        .bin_q (cnt_q.bin),
        .rst   (rst),
        .en    (en),
        .bin_d (bin_nx_d)
    );

    // The Gray next value is taken from the binary next value, not from the register.
    gray_enc_stage #(.WIDTH(WIDTH)) u_gray_enc (
        .bin_d  (bin_nx_d),
        .gray_d (gray_nx_d)
    );

    always_comb begin
        cnt_d      = cnt_q;
        cnt_d.bin  = bin_nx_d;
        cnt_d.gray = gray_nx_d;
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    assign bin_o  = cnt_q.bin;
    assign gray_o = cnt_q.gray;

    // Assertions
    logic past_ok_q;
    always_ff @(posedge clk) past_ok_q <= 1'b1;

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (bin_o == '0 && gray_o == '0));

    a_r2_increment: assert property (@(posedge clk) disable iff (rst)
        (past_ok_q && en) |=> bin_o == $past(bin_o) + WIDTH'(1));

    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (past_ok_q && !en) |=> ($stable(bin_o) && $stable(gray_o)));

    a_r4_gray_matches: assert property (@(posedge clk) disable iff (rst)
        past_ok_q && !$past(rst) |-> gray_o == (bin_o ^ (bin_o >> 1)));

    a_r5_single_bit: assert property (@(posedge clk) disable iff (rst)
        (past_ok_q && en) |=> $countones(gray_o ^ $past(gray_o)) == 1);

    a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
        (past_ok_q && en && bin_o == '1) |=> (bin_o == '0 && gray_o == '0));
endmodule

// File: tb/gray_bin_counter_tb.sv
module gray_bin_counter_tb;
    localparam int  WIDTH = 4;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic [WIDTH-1:0] bin_o, gray_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct packed {
        logic [WIDTH-1:0] bin;
        logic [WIDTH-1:0] gray;
        logic [7:0]       req;
    } exp_t;

    exp_t exp_q[$];
    logic [WIDTH-1:0] model_bin = '0;
    logic [WIDTH-1:0] prev_gray = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gray_bin_counter #(.WIDTH(WIDTH)) u_dut (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .bin_o  (bin_o),
        .gray_o (gray_o)
    );

    function automatic logic [WIDTH-1:0] gray_of(input logic [WIDTH-1:0] b);
        logic [WIDTH-1:0] g;
        for (int i = 0; i < WIDTH - 1; i++) g[i] = b[i] ^ b[i+1];
        g[WIDTH-1] = b[WIDTH-1];
        return g;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Driver: apply one cycle of stimulus and push the expected result.
    task automatic drive(input logic r, input logic e);
        logic [7:0] tag;
        @(negedge clk);
        rst = r;
        en  = e;
        if (r) begin
            model_bin = '0;
            tag = 8'd1;
        end else if (e) begin
            tag = (model_bin == '1) ? 8'd6 : 8'd2;
            model_bin = model_bin + 1'b1;
        end else begin
            tag = 8'd3;
        end
        exp_q.push_back('{bin: model_bin, gray: gray_of(model_bin), req: tag});
    endtask

    // Monitor: the result of the edge after a drive is sampled at the next negedge.
    initial begin
        @(negedge clk);
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t x;
                string rq;
                x = exp_q.pop_front();
                case (x.req)
                    8'd1:    rq = "R1";
                    8'd3:    rq = "R3";
                    8'd6:    rq = "R6";
                    default: rq = "R2";
                endcase
                check(bin_o == x.bin, rq, bin_o, x.bin);
                check(gray_o == x.gray, "R4", gray_o, x.gray);
                if (x.req == 8'd2 || x.req == 8'd6)
                    check($countones(gray_o ^ prev_gray) == 1, "R5",
                          gray_o ^ prev_gray, 1);
                prev_gray = gray_o;
            end
        end
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        check(WIDTH >= 2, "R7", WIDTH, 2);
        drive(1'b1, 1'b0);                        // R1 reset
        drive(1'b1, 1'b1);                        // R1: reset wins over enable
        for (int k = 0; k < 5; k++) drive(1'b0, 1'b1);   // R2 counting
        for (int k = 0; k < 3; k++) drive(1'b0, 1'b0);   // R3 hold
        for (int k = 0; k < 20; k++) drive(1'b0, (k % 3) != 1); // mixed, passes wrap R6
        for (int k = 0; k < 2 * (1 << WIDTH); k++) drive(1'b0, 1'b1); // R6 wrap twice
        drive(1'b1, 1'b1);                        // R1 mid-count reset
        for (int k = 0; k < 4; k++) drive(1'b0, 1'b1);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule